// File: doc/BRIEF.md
# Byte-Serial Synchronous Port Controller

This block is a byte-wide synchronous serial peripheral with a three-register CPU interface. It can act as the bus master, generating the serial clock from the system clock at one of six rates, or as a slave clocked by an external master. Every transfer is full duplex: each byte sent shifts in a byte from the other side, most significant bit first. Clock idle level and sampling phase are programmable. The data output can be released to high impedance so that the port only receives, which gives two-wire simplex operation.

A byte written to the data register starts a master transfer, or in slave mode is held until the master clocks it out. A finished byte goes into a separate read buffer. The end of each byte raises a done flag, and that flag drives the interrupt line when the interrupt enable bit is set. Three error flags are reported. A collision flag is set when the data register is written mid-transfer. An overrun flag is set when a byte completes while the done flag is still pending. A mode-fault flag is set when a master sees its select input driven active. The select level comes either from the select pin or from a software bit.

Top module: `spi_port`

Register map: `bus_addr` 0 is control, 1 is status, 2 is data. Control bits: [0] enable, [1] master, [2] clock idle level (pol), [3] phase (pha), [6:4] rate code, [7] interrupt enable. Status bits: [0] done, [1] collision, [2] overrun, [3] mode fault (bits 0 to 3 read-only), [4] software select level, [5] software select mode, [6] output disable, [7] reads 0.

## Requirements
- R1: After reset, all three registers read 0x00, `irq` is low and `sck_oe`, `mosi_oe` and `miso_oe` are all low.
- R2: In master mode, each half period of `sck_o` lasts 2, 4, 8, 16, 32 or 64 system clocks for rate codes 0 to 5. Codes 6 and 7 give 2.
- R3: A master transfer sends the written byte MSB first on `mosi_o` and captures a byte from `miso_i` that is then read from the data register. With pha=0 data is sampled on the odd SCK edges and with pha=1 on the even edges. `sck_o` idles at the pol level.
- R4: At the end of each byte the done flag (status bit 0) is set, and `irq` is high while both the done flag and the interrupt enable are set.
- R5: Writing the data register during a transfer sets the collision flag (status bit 1), and the transfer continues with the original byte.
- R6: When a byte completes while the done flag is already set, the overrun flag (status bit 2) is set and the read buffer keeps the earlier byte.
- R7: A status read taken while done, collision or overrun is set, followed by a data register read or write, clears those three flags. A data access with no such status read before it leaves them set.
- R8: An enabled master whose internal select level is low sets the mode-fault flag (status bit 3) and clears control bits 0 and 1. The flag is cleared by a status read taken while it is set, followed by a control write.
- R9: With status bit 5 set, the internal select level is status bit 4 and the `ss_n_i` pin is ignored. With bit 5 clear, the level is taken from `ss_n_i`.
- R10: An enabled, selected slave shifts in `mosi_i` and drives `miso_o` on the edges set by pol and pha, then sets the done flag. `miso_oe` is high only while the slave is enabled and selected.
- R11: With status bit 6 set, `mosi_oe` stays low in master mode and `miso_oe` stays low in slave mode.
- R12: If a transfer completes in the same cycle as a clearing data access, the done flag stays set, the overrun flag stays clear, and the new byte goes into the read buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock input in slave mode |
| sck_o | output | 1 | Serial clock output in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data input in slave mode |
| mosi_o | output | 1 | Serial data output in master mode |
| mosi_oe | output | 1 | Master data output enable |
| miso_i | input | 1 | Serial data input in master mode |
| miso_o | output | 1 | Serial data output in slave mode |
| miso_oe | output | 1 | Slave data output enable |
| ss_n_i | input | 1 | Slave-select pin, active low |

## Verification
The end of a byte and the clearing data access that follows a status read can land on the same clock edge. Whichever wins decides whether the new byte is kept or reported as an overrun. The bench starts a master transfer at the fastest rate while an old byte is still pending, so the transfer ends exactly 32 clocks after the write. It arms the clear with a status read and then times a data read to fall on that completing edge. The result is judged by the status register, which must show done set and overrun clear, and by the next data read, which must return the new byte.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int unsigned HALF_W = 7;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic       ie;
    logic [2:0] rate;
    logic       pha;
    logic       pol;
    logic       master;
    logic       en;
  } ctrl_t;

  // System clocks per SCK half period for a rate code.
  function automatic logic [HALF_W-1:0] half_cycles(input logic [2:0] code);
    if (code > 3'd5) return HALF_W'(2);
    return HALF_W'(2) << code;
  endfunction
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] lim;

  assign lim  = half_cycles(code) - HALF_W'(1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + HALF_W'(1);
  end

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= lim);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         master,
  input  logic         pol,
  input  logic         pha,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         abort,
  input  logic         tick,
  input  logic         sck_in,
  input  logic         sel,
  input  logic         din,
  output logic         run,
  output logic         busy,
  output logic         sck_drv,
  output logic         dout,
  output logic         done,
  output logic [W-1:0] rx
);
  localparam int unsigned EDGES = 2 * W;
  localparam int unsigned CW    = $clog2(EDGES + 1);

  logic [CW-1:0] ecnt;
  logic [W-1:0]  sh;
  logic          sck_q;
  logic          sl_edge, m_edge, edge_ev, first, capture, last;

  assign sl_edge = en && !master && sel && (sck_in != sck_q);
  assign m_edge  = en && master && run && tick;
  assign edge_ev = m_edge || sl_edge;
  assign first   = !ecnt[0];
  assign capture = edge_ev && (first ^ pha);
  assign last    = edge_ev && (ecnt == CW'(EDGES - 1));
  assign done    = last && !load && !abort;
  assign rx      = capture ? {sh[W-2:0], din} : sh;
  assign busy    = run || (ecnt != '0);
  assign sck_drv = pol ^ ecnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
      sh   <= '0;
      dout <= 1'b0;
      run  <= 1'b0;
    end else if (load) begin
      sh   <= load_data;
      dout <= load_data[W-1];
      run  <= master;
      ecnt <= '0;
    end else if (abort || !en || (!master && !sel)) begin
      ecnt <= '0;
      run  <= 1'b0;
    end else if (edge_ev) begin
      if (capture) sh   <= {sh[W-2:0], din};
      else         dout <= sh[W-1];
      if (last) begin
        ecnt <= '0;
        run  <= 1'b0;
      end else begin
        ecnt <= ecnt + CW'(1);
      end
    end
  end

  a_r3_edge_range: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt < CW'(EDGES));
  a_r2_edge_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && master && !tick && !load && !abort) |=> $stable(ecnt));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_n_i
);
  ctrl_t         ctrl;
  logic          done_f, wcol_f, ovr_f, modf_f;
  logic          sod, ssm, ssi, armed, fault_armed;
  logic [DW-1:0] rbuf;

  logic          ss_lvl, is_m, is_s;
  logic          wr_ctrl, wr_stat, wr_data, rd_stat, rd_data, data_acc;
  logic          fault_evt, load, wcol_evt, clr, ovr_evt;
  logic          tick, run, busy, sck_drv, dout, eng_done;
  logic [DW-1:0] rx;

  assign ss_lvl    = ssm ? ssi : ss_n_i;
  assign is_m      = ctrl.en && ctrl.master;
  assign is_s      = ctrl.en && !ctrl.master && !ss_lvl;
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat   = bus_wr && (bus_addr == A_STAT);
  assign wr_data   = bus_wr && (bus_addr == A_DATA);
  assign rd_stat   = bus_rd && (bus_addr == A_STAT);
  assign rd_data   = bus_rd && (bus_addr == A_DATA);
  assign data_acc  = wr_data || rd_data;
  assign fault_evt = is_m && !ss_lvl;
  assign load      = wr_data && !busy && ctrl.en && !fault_evt;
  assign wcol_evt  = wr_data && busy;
  assign clr       = data_acc && armed;
  assign ovr_evt   = eng_done && done_f && !clr;

  spi_rate_gen u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (ctrl.rate),
    .tick (tick)
  );

  spi_shift_engine #(.W(DW)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl.en),
    .master   (ctrl.master),
    .pol      (ctrl.pol),
    .pha      (ctrl.pha),
    .load     (load),
    .load_data(bus_wdata),
    .abort    (fault_evt),
    .tick     (tick),
    .sck_in   (sck_i),
    .sel      (!ss_lvl),
    .din      (ctrl.master ? miso_i : mosi_i),
    .run      (run),
    .busy     (busy),
    .sck_drv  (sck_drv),
    .dout     (dout),
    .done     (eng_done),
    .rx       (rx)
  );

  // Control register and mode fault
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl        <= '0;
      modf_f      <= 1'b0;
      fault_armed <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata);
      if (fault_evt) begin
        ctrl.en     <= 1'b0;
        ctrl.master <= 1'b0;
        modf_f      <= 1'b1;
      end else if (wr_ctrl && fault_armed) begin
        modf_f <= 1'b0;
      end
      if (wr_ctrl)                fault_armed <= 1'b0;
      else if (rd_stat && modf_f) fault_armed <= 1'b1;
    end
  end

  // Status configuration bits, transfer flags and read buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sod, ssm, ssi}          <= '0;
      {done_f, wcol_f, ovr_f}  <= '0;
      armed                    <= 1'b0;
      rbuf                     <= '0;
    end else begin
      if (wr_stat) {sod, ssm, ssi} <= bus_wdata[6:4];
      if (eng_done)  done_f <= 1'b1;
      else if (clr)  done_f <= 1'b0;
      if (wcol_evt)  wcol_f <= 1'b1;
      else if (clr)  wcol_f <= 1'b0;
      if (ovr_evt)   ovr_f  <= 1'b1;
      else if (clr)  ovr_f  <= 1'b0;
      if (eng_done && !ovr_evt) rbuf <= rx;
      if (clr) armed <= 1'b0;
      else if (rd_stat && (done_f || wcol_f || ovr_f)) armed <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'(ctrl);
      A_STAT:  bus_rdata = DW'({1'b0, sod, ssm, ssi, modf_f, ovr_f, wcol_f, done_f});
      A_DATA:  bus_rdata = rbuf;
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = ctrl.ie && done_f;
  assign sck_o   = is_m ? sck_drv : ctrl.pol;
  assign sck_oe  = is_m;
  assign mosi_o  = dout;
  assign mosi_oe = is_m && !sod;
  assign miso_o  = dout;
  assign miso_oe = is_s && !sod;

  a_r4_done_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> done_f);
  a_r5_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_evt |=> wcol_f);
  a_r6_overrun_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (ovr_f && $stable(rbuf)));
  a_r7_no_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !armed && done_f) |=> done_f);
  a_r8_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (modf_f && !ctrl.en && !ctrl.master));
  a_r11_output_disable: assert property (@(posedge clk) disable iff (!rst_n)
    sod |-> (!mosi_oe && !miso_oe));
  a_r12_end_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && clr) |=> (done_f && !ovr_f));
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

  always #10 clk = ~clk;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs change right after a falling edge and are sampled at the next rising edge.
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic int exp_half(input logic [2:0] code);
    case (code)
      3'd0: return 2;   3'd1: return 4;   3'd2: return 8;
      3'd3: return 16;  3'd4: return 32;  3'd5: return 64;
      default: return 2;
    endcase
  endfunction

  // Bench-side slave attached to the master pins.
  bit         m_act = 1'b0, m_pha = 1'b0;
  int         m_edges = 0;
  logic [7:0] m_tx = '0, m_rx = '0;
  time        t_e1 = 0, t_e2 = 0;

  always @(sck_o) if (m_act) begin
    m_edges++;
    if (m_edges == 1) t_e1 = $time;
    if (m_edges == 2) t_e2 = $time;
    if (((m_edges % 2) == 1) ^ m_pha) m_rx = {m_rx[6:0], mosi_o};
    else begin miso_i = m_tx[7]; m_tx = m_tx << 1; end
  end

  task automatic arm_model(input logic pha, input logic [7:0] stx);
    m_act = 1'b1; m_edges = 0; m_rx = '0; m_pha = pha; m_tx = stx;
    if (!pha) begin miso_i = m_tx[7]; m_tx = m_tx << 1; end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 5000 && !irq; i++) @(negedge clk);
  endtask

  // Bench-side master driving a slave-mode port; 8 system clocks per half period.
  task automatic slave_xfer(input logic pol, input logic pha, input logic [7:0] mtx,
                            output logic [7:0] srx);
    logic [7:0] mt;
    mt = mtx; srx = '0;
    sck_i = pol; ss_n_i = 1'b0;
    if (!pha) begin mosi_i = mt[7]; mt = mt << 1; end
    repeat (8) @(negedge clk);
    chk("R10 miso_oe while selected", miso_oe, 1);
    for (int e = 1; e <= 16; e++) begin
      if (((e % 2) == 1) ^ pha) srx = {srx[6:0], miso_o};
      sck_i = ~sck_i;
      if (!(((e % 2) == 1) ^ pha)) begin mosi_i = mt[7]; mt = mt << 1; end
      repeat (8) @(negedge clk);
    end
    ss_n_i = 1'b1;
    @(negedge clk);
  endtask

  // {pol, pha, rate[2:0], master byte, slave byte}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 3'd1, 8'h5A, 8'hC3},
    {1'b1, 1'b0, 3'd2, 8'h81, 8'h7E},
    {1'b1, 1'b1, 3'd3, 8'hFF, 8'h00},
    {1'b0, 1'b0, 3'd4, 8'h00, 8'hFF},
    {1'b1, 1'b1, 3'd5, 8'hC6, 8'h39},
    {1'b0, 1'b1, 3'd6, 8'h12, 8'h34},
    {1'b1, 1'b0, 3'd7, 8'hE7, 8'h18}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, rd2, srx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rd); chk("R1 ctrl", rd, 8'h00);
    bus_read(2'd1, rd); chk("R1 status", rd, 8'h00);
    bus_read(2'd2, rd); chk("R1 data", rd, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 oe", {sck_oe, mosi_oe, miso_oe}, 3'b000);

    // R2 R3 R4 R7: table-driven master transfers
    for (int v = 0; v < 8; v++) begin
      logic pol, pha; logic [2:0] rate; logic [7:0] tx, stx;
      {pol, pha, rate, tx, stx} = VEC[v];
      bus_write(2'd1, 8'h30);
      bus_write(2'd0, {1'b1, rate, pha, pol, 2'b11});
      chk("R3 sck idle level", sck_o, pol);
      arm_model(pha, stx);
      bus_write(2'd2, tx);
      wait_irq();
      chk("R4 irq at end", irq, 1);
      @(negedge clk);
      m_act = 1'b0;
      chk("R3 sck back to idle", sck_o, pol);
      chk("R2 half period", 32'((t_e2 - t_e1) / 20), exp_half(rate));
      chk("R3 bits sent msb first", m_rx, tx);
      bus_read(2'd1, rd); chk("R4 done flag", rd, 8'h31);
      bus_read(2'd2, rd); chk("R3 received byte", rd, stx);
      bus_read(2'd1, rd); chk("R7 flags cleared", rd, 8'h30);
      chk("R4 irq cleared", irq, 0);
    end

    // R5 collision during transfer
    bus_write(2'd0, 8'b1_010_0_0_11);
    arm_model(1'b0, 8'h66);
    bus_write(2'd2, 8'h99);
    repeat (20) @(negedge clk);
    bus_write(2'd2, 8'h11);
    wait_irq(); @(negedge clk); m_act = 1'b0;
    chk("R5 original byte kept", m_rx, 8'h99);
    bus_read(2'd1, rd); chk("R5 collision flag", rd, 8'h33);
    bus_read(2'd2, rd); chk("R5 received", rd, 8'h66);
    bus_read(2'd1, rd); chk("R7 clear after collision", rd, 8'h30);

    // R6 overrun and R7 unarmed access
    bus_write(2'd0, 8'b1_000_0_0_11);
    arm_model(1'b0, 8'hAB);
    bus_write(2'd2, 8'h01);
    wait_irq(); @(negedge clk);
    bus_read(2'd2, rd);
    chk("R7 data read without status read", irq, 1);
    arm_model(1'b0, 8'hCD);
    bus_write(2'd2, 8'h02);
    repeat (60) @(negedge clk); m_act = 1'b0;
    bus_read(2'd1, rd); chk("R6 overrun flag", rd, 8'h35);
    bus_read(2'd2, rd); chk("R6 older byte kept", rd, 8'hAB);
    bus_read(2'd1, rd); chk("R7 clear after overrun", rd, 8'h30);

    // R12 completion and clear on the same edge
    arm_model(1'b0, 8'h11);
    bus_write(2'd2, 8'h44);
    wait_irq(); @(negedge clk);
    arm_model(1'b0, 8'h5E);
    bus_write(2'd2, 8'h22);
    bus_read(2'd1, rd);
    repeat (30) @(negedge clk);
    bus_read(2'd2, rd2);
    m_act = 1'b0;
    chk("R12 old byte read", rd2, 8'h11);
    bus_read(2'd1, rd); chk("R12 done kept, no overrun", rd, 8'h31);
    bus_read(2'd2, rd); chk("R12 new byte buffered", rd, 8'h5E);

    // R8 mode fault from the pin
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'h03);
    ss_n_i = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(2'd1, rd); chk("R8 fault flag", rd, 8'h08);
    bus_read(2'd0, rd); chk("R8 enable and master cleared", rd, 8'h00);
    chk("R8 sck released", sck_oe, 0);
    ss_n_i = 1'b1;
    bus_write(2'd0, 8'h00);
    bus_read(2'd1, rd); chk("R8 fault cleared", rd, 8'h00);

    // R9 software select overrides the pin
    ss_n_i = 1'b0;
    bus_write(2'd1, 8'h30);
    bus_write(2'd0, 8'h03);
    repeat (2) @(negedge clk);
    bus_read(2'd1, rd); chk("R9 pin ignored", rd, 8'h30);
    bus_write(2'd1, 8'h20);
    repeat (2) @(negedge clk);
    bus_read(2'd1, rd); chk("R9 soft level faults", rd, 8'h28);
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h00);
    ss_n_i = 1'b1;

    // R10 slave transfers
    bus_write(2'd0, 8'b0_000_0_0_01);
    chk("R10 miso_oe deselected", miso_oe, 0);
    bus_write(2'd2, 8'hB4);
    slave_xfer(1'b0, 1'b0, 8'h2D, srx);
    chk("R10 slave sent pha0", srx, 8'hB4);
    bus_read(2'd1, rd); chk("R10 done pha0", rd, 8'h01);
    bus_read(2'd2, rd); chk("R10 slave got pha0", rd, 8'h2D);
    bus_write(2'd0, 8'b0_000_1_1_01);
    sck_i = 1'b1;
    @(negedge clk);
    bus_write(2'd2, 8'h69);
    slave_xfer(1'b1, 1'b1, 8'hD2, srx);
    chk("R10 slave sent pha1", srx, 8'h69);
    bus_read(2'd1, rd); chk("R10 done pha1", rd, 8'h01);
    bus_read(2'd2, rd); chk("R10 slave got pha1", rd, 8'hD2);

    // R11 output disable, R9 soft select in slave mode
    bus_write(2'd1, 8'h60);
    chk("R11 miso disabled", miso_oe, 0);
    bus_write(2'd1, 8'h20);
    chk("R9 slave selected by soft level", miso_oe, 1);
    bus_write(2'd1, 8'h70);
    bus_write(2'd0, 8'h03);
    chk("R11 mosi disabled", {sck_oe, mosi_oe}, 2'b10);
    bus_write(2'd1, 8'h30);
    chk("R11 mosi enabled", mosi_oe, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule